// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a run of words between one I/O device data port and main memory with no processor involvement per word. Before a run starts, the processor loads four registers through a small write/read port: the starting memory address, the number of words, a data holding register and a control/status word. Writing the control word with its go bit set starts the run.

The engine asks for the memory bus on a request output and makes no memory access until the bus owner answers on an acknowledge input. Two ownership styles are available. In cycle-stealing style the engine moves one word per grant, then releases the bus and asks again, so its accesses interleave with processor accesses. In burst style it keeps the bus from the first word to the last. After each word the address steps up by one and the remaining count steps down by one. A device error ends the run early. Every run ends with an interrupt that stays high until the processor acknowledges it.

Top module: `dma_engine`

## Requirements
- R1: After reset the request and interrupt outputs are low, no memory access is made, and the address, count, holding and control/status registers all read as zero.
- R2: Register writes are accepted only while the engine is idle. Select 0 is the start address, 1 the word count, 2 the data holding register, and 3 the control/status word. A write made while a run or its interrupt is pending changes nothing.
- R3: A memory access (mem_en high) is made only in a cycle where the request output and the acknowledge input are both high.
- R4: Each moved word uses the current address register as the memory address. On the next cycle the address has gone up by one and the count has gone down by one. The run ends after the word that takes the count to zero.
- R5: Control bit 1 sets the direction. With 0, device words are written to memory (mem_we high, mem_wdata equal to dev_rdata). With 1, memory words are read and presented on dev_wdata. dev_strobe marks each moved word, and the holding register keeps the last moved word.
- R6: When control bit 2 is 0 (cycle-stealing), the request output is low in the cycle after every moved word.
- R7: When control bit 2 is 1 (burst), the request output stays high from the start until the last word moves, even when the device is briefly not ready.
- R8: In cycle-stealing style, a grant that arrives while the device is not ready drops the request on the next cycle with no access. The request returns one cycle after the device reports ready.
- R9: Starting with a count of zero raises the interrupt in the next cycle, with no bus request at all.
- R10: The interrupt rises in the cycle after the run ends and stays high until inta is sampled high. It is low in the following cycle. The status done bit (bit 3) is set while the interrupt is pending and after it.
- R11: dev_err during a run makes no further access, drops the request in the next cycle, sets status error bit 4 and raises the interrupt. The count keeps the number of words not moved.
- R12: No word moves in a cycle where dev_ready is low. The status word reads busy in bit 0 while a run is in progress, and reads back the direction and style in bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Selected register value, combinational |
| dmar | output | 1 | Memory bus request |
| dmaa | input | 1 | Memory bus acknowledge |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the access cycle |
| dev_ready | input | 1 | Device can move a word |
| dev_err | input | 1 | Device error, aborts the run |
| dev_rdata | input | DW | Word offered by the device |
| dev_wdata | output | DW | Word delivered to the device |
| dev_strobe | output | 1 | A word moves this cycle |
| intr | output | 1 | Completion interrupt |
| inta | input | 1 | Interrupt acknowledge |

## Verification
Memory access, the address and write data, dev_strobe and the holding-register readback depend on dmaa, dev_ready and dev_err in the same cycle. The bench therefore compares them in that cycle, two time units after the falling edge at which it drives its inputs. The request, the interrupt and the register updates change one clock edge after the deciding input. This covers request release after a word, abort on error, the interrupt after the last word or a zero-count start, and the drop of the interrupt after inta. The bench keeps the reference state it updates at each rising edge and compares that state only at the following falling edge, so each expectation is due exactly one edge after its cause. Directed checks add the final memory and device contents, the counts of request drops, and status reads.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_REST = 2'd2,
      ST_IRQ  = 2'd3
   } dma_state_e;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_BUF  = 2'd2;
   localparam logic [1:0] SEL_CSR  = 2'd3;

   localparam int B_GO    = 0;
   localparam int B_BUSY  = 0;
   localparam int B_DIR   = 1;
   localparam int B_BURST = 2;
   localparam int B_DONE  = 3;
   localparam int B_ERR   = 4;
   localparam int CSR_MIN = 5;
endpackage

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cnt_zero,
   input  logic       cnt_last,
   input  logic       burst,
   input  logic       dmaa,
   input  logic       dev_ready,
   input  logic       dev_err,
   input  logic       inta,
   output dma_state_e state,
   output logic       xfer,
   output logic       finish,
   output logic       abort
);
   dma_state_e nxt;

   always_comb begin
      nxt   = state;
      xfer  = 1'b0;
      abort = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) nxt = cnt_zero ? ST_IRQ : ST_REQ;
         end
         ST_REQ: begin
            if (dev_err) begin
               abort = 1'b1;
               nxt   = ST_IRQ;
            end else if (dmaa && dev_ready) begin
               xfer = 1'b1;
               if (cnt_last)   nxt = ST_IRQ;
               else if (!burst) nxt = ST_REST;
            end else if (dmaa && !burst) begin
               nxt = ST_REST;
            end
         end
         ST_REST: begin
            if (dev_err) begin
               abort = 1'b1;
               nxt   = ST_IRQ;
            end else if (dev_ready) begin
               nxt = ST_REQ;
            end
         end
         ST_IRQ: begin
            if (inta) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign finish = (nxt == ST_IRQ) && (state != ST_IRQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
   import dma_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    sel,
   input  logic [DW-1:0] wdata,
   input  logic          xfer,
   input  logic          finish,
   input  logic          abort,
   input  logic          busy,
   input  logic [DW-1:0] dev_word,
   input  logic [DW-1:0] mem_word,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          dir_q,
   output logic          burst_q,
   output logic          done_q,
   output logic          err_q,
   output logic          start,
   output logic [DW-1:0] rdata
);
   localparam int APAD = DW - AW;
   localparam int CPAD = DW - CW;

   logic [DW-1:0] buf_q;
   logic [DW-1:0] addr_ext;
   logic [DW-1:0] cnt_ext;
   logic [DW-1:0] stat;

   assign start = wr_en && (sel == SEL_CSR) && wdata[B_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         buf_q   <= '0;
         dir_q   <= 1'b0;
         burst_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (wr_en) begin
            unique case (sel)
               SEL_ADDR: addr_q <= wdata[AW-1:0];
               SEL_CNT:  cnt_q  <= wdata[CW-1:0];
               SEL_BUF:  buf_q  <= wdata;
               default: begin
                  dir_q   <= wdata[B_DIR];
                  burst_q <= wdata[B_BURST];
               end
            endcase
         end
         if (start) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (xfer) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            buf_q  <= dir_q ? mem_word : dev_word;
         end
         if (finish) done_q <= 1'b1;
         if (abort)  err_q  <= 1'b1;
      end
   end

   generate
      if (APAD > 0) begin : g_apad
         assign addr_ext = {{APAD{1'b0}}, addr_q};
      end else begin : g_afull
         assign addr_ext = addr_q;
      end
      if (CPAD > 0) begin : g_cpad
         assign cnt_ext = {{CPAD{1'b0}}, cnt_q};
      end else begin : g_cfull
         assign cnt_ext = cnt_q;
      end
   endgenerate

   always_comb begin
      stat          = '0;
      stat[B_BUSY]  = busy;
      stat[B_DIR]   = dir_q;
      stat[B_BURST] = burst_q;
      stat[B_DONE]  = done_q;
      stat[B_ERR]   = err_q;
   end

   always_comb begin
      unique case (sel)
         SEL_ADDR: rdata = addr_ext;
         SEL_CNT:  rdata = cnt_ext;
         SEL_BUF:  rdata = buf_q;
         default:  rdata = stat;
      endcase
   end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
   import dma_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          dmar,
   input  logic          dmaa,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          dev_ready,
   input  logic          dev_err,
   input  logic [DW-1:0] dev_rdata,
   output logic [DW-1:0] dev_wdata,
   output logic          dev_strobe,
   output logic          intr,
   input  logic          inta
);
   generate
      if (DW < CSR_MIN) begin : g_bad_dw
         $error("dma_engine: DW too small for the status word");
      end
      if (AW < 1 || AW > DW) begin : g_bad_aw
         $error("dma_engine: AW must be 1..DW");
      end
      if (CW < 1 || CW > DW) begin : g_bad_cw
         $error("dma_engine: CW must be 1..DW");
      end
   endgenerate

   dma_state_e    state;
   logic          xfer, finish, abort, start, busy, wr_en;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          dir_q, burst_q, done_q, err_q;

   assign wr_en = reg_wr && (state == ST_IDLE);
   assign busy  = (state == ST_REQ) || (state == ST_REST);

   dma_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cnt_zero  (cnt_q == '0),
      .cnt_last  (cnt_q == CW'(1)),
      .burst     (burst_q),
      .dmaa      (dmaa),
      .dev_ready (dev_ready),
      .dev_err   (dev_err),
      .inta      (inta),
      .state     (state),
      .xfer      (xfer),
      .finish    (finish),
      .abort     (abort)
   );

   dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .xfer     (xfer),
      .finish   (finish),
      .abort    (abort),
      .busy     (busy),
      .dev_word (dev_rdata),
      .mem_word (mem_rdata),
      .addr_q   (addr_q),
      .cnt_q    (cnt_q),
      .dir_q    (dir_q),
      .burst_q  (burst_q),
      .done_q   (done_q),
      .err_q    (err_q),
      .start    (start),
      .rdata    (reg_rdata)
   );

   assign dmar       = (state == ST_REQ);
   assign intr       = (state == ST_IRQ);
   assign mem_en     = xfer;
   assign mem_we     = xfer && !dir_q;
   assign mem_addr   = addr_q;
   assign mem_wdata  = dev_rdata;
   assign dev_wdata  = mem_rdata;
   assign dev_strobe = xfer;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dmar,
   input logic          dmaa,
   input logic          mem_en,
   input logic [AW-1:0] mem_addr,
   input logic          dev_ready,
   input logic          dev_err,
   input logic          intr,
   input logic          inta,
   input logic [CW-1:0] cnt_q,
   input logic          burst_q,
   input logic          done_q,
   input logic          err_q
);
   // R3
   granted_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (dmar && dmaa));

   // R12
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (dev_ready && !dev_err));

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |=> (($past(cnt_q) - cnt_q) == CW'(1)));

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |=> ((mem_addr - $past(mem_addr)) == AW'(1)));

   // R6
   steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !burst_q) |=> !dmar);

   // R7
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dmar && burst_q && !dev_err && !(mem_en && cnt_q == CW'(1))) |=> dmar);

   // R10
   intr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intr && !inta) |=> intr);

   // R10
   intr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr) |-> done_q);

   // R11
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_err && dmar) |=> (!dmar && !mem_en && err_q && intr));
endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dmar      (dmar),
   .dmaa      (dmaa),
   .mem_en    (mem_en),
   .mem_addr  (mem_addr),
   .dev_ready (dev_ready),
   .dev_err   (dev_err),
   .intr      (intr),
   .inta      (inta),
   .cnt_q     (cnt_q),
   .burst_q   (burst_q),
   .done_q    (done_q),
   .err_q     (err_q)
);

// File: tb/dma_engine_tb_top.sv
module dma_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        dmar, mem_en, mem_we, dev_strobe, intr;
   logic        dmaa = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
   logic        dev_ready = 1'b1;
   logic        dev_err = 1'b0;
   logic        inta = 1'b0;
   logic        grant_en = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   logic [15:0] memarr [0:63];
   int          dev_idx = 0;
   logic [15:0] devq [$];
   int          n_xfer = 0;
   int          n_drop = 0;
   int          n_req  = 0;
   logic        prev_dmar = 1'b0;

   assign mem_rdata = memarr[mem_addr[5:0]];
   assign dev_rdata = 16'hA000 + dev_idx[15:0];

   dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dmar(dmar), .dmaa(dmaa),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_ready(dev_ready),
      .dev_err(dev_err), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
      .dev_strobe(dev_strobe), .intr(intr), .inta(inta)
   );

   // memory and device side
   always @(posedge clk) begin
      if (rst_n && mem_en && mem_we) memarr[mem_addr[5:0]] <= mem_wdata;
      if (rst_n && dev_strobe && mem_we) dev_idx <= dev_idx + 1;
      if (rst_n && dev_strobe && !mem_we) devq.push_back(dev_wdata);
      if (rst_n && mem_en) n_xfer <= n_xfer + 1;
   end

   // bus owner: grant one cycle after a request
   always @(negedge clk) begin
      if (prev_dmar && !dmar) n_drop = n_drop + 1;
      if (!prev_dmar && dmar) n_req = n_req + 1;
      prev_dmar = dmar;
      dmaa = grant_en && dmar && rst_n;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // reference model: 0 idle, 1 requesting, 2 released, 3 interrupt pending
   int          ph = 0;
   logic [15:0] m_addr = '0, m_cnt = '0, m_buf = '0;
   bit          m_dir = 0, m_burst = 0, m_done = 0, m_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_addr = '0; m_cnt = '0; m_buf = '0;
         m_dir = 0; m_burst = 0; m_done = 0; m_err = 0;
      end else begin
         case (ph)
            0: if (reg_wr) begin
                  if (reg_sel == 2'd0) m_addr = reg_wdata;
                  else if (reg_sel == 2'd1) m_cnt = reg_wdata;
                  else if (reg_sel == 2'd2) m_buf = reg_wdata;
                  else begin
                     m_dir = reg_wdata[1];
                     m_burst = reg_wdata[2];
                     if (reg_wdata[0]) begin
                        m_done = 0; m_err = 0;
                        if (m_cnt == 0) begin ph = 3; m_done = 1; end
                        else ph = 1;
                     end
                  end
               end
            1: if (dev_err) begin
                  ph = 3; m_err = 1; m_done = 1;
               end else if (dmaa && dev_ready) begin
                  m_buf = m_dir ? memarr[m_addr[5:0]] : dev_rdata;
                  m_addr = m_addr + 1;
                  m_cnt = m_cnt - 1;
                  if (m_cnt == 0) begin ph = 3; m_done = 1; end
                  else if (!m_burst) ph = 2;
               end else if (dmaa && !m_burst) ph = 2;
            2: if (dev_err) begin
                  ph = 3; m_err = 1; m_done = 1;
               end else if (dev_ready) ph = 1;
            default: if (inta) ph = 0;
         endcase
      end
   end

   // per-cycle comparison, 2 units after the input-driving edge
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         logic        e_x;
         logic [15:0] e_rd;
         e_x = (ph == 1) && dmaa && dev_ready && !dev_err;
         case (reg_sel)
            2'd0: e_rd = m_addr;
            2'd1: e_rd = m_cnt;
            2'd2: e_rd = m_buf;
            default: e_rd = {11'd0, m_err, m_done, m_burst, m_dir, (ph == 1 || ph == 2)};
         endcase
         chk(dmar == (ph == 1), "R6", "dmar", dmar, ph == 1);
         chk(intr == (ph == 3), "R10", "intr", intr, ph == 3);
         chk(mem_en == e_x, "R12", "mem_en", mem_en, e_x);
         chk(dev_strobe == e_x, "R5", "dev_strobe", dev_strobe, e_x);
         chk(reg_rdata == e_rd, "R2", "reg_rdata", reg_rdata, e_rd);
         if (e_x) begin
            chk(mem_addr == m_addr, "R4", "mem_addr", mem_addr, m_addr);
            chk(mem_we == !m_dir, "R5", "mem_we", mem_we, !m_dir);
            if (!m_dir) chk(mem_wdata == dev_rdata, "R5", "mem_wdata", mem_wdata, dev_rdata);
            else chk(dev_wdata == memarr[m_addr[5:0]], "R5", "dev_wdata", dev_wdata, memarr[m_addr[5:0]]);
         end
      end
   end

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      reg_sel = s;
      #1 v = reg_rdata;
   endtask

   task automatic wait_intr();
      for (int k = 0; k < 2000 && !intr; k++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic ack();
      @(negedge clk); inta = 1'b1;
      @(negedge clk); inta = 1'b0;
   endtask

   task automatic run_all();
      logic [15:0] v;
      int x0, d0, r0;
      for (int i = 0; i < 64; i++) memarr[i] = 16'h5000 + i[15:0];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(!dmar && !intr && !mem_en, "R1", "outputs after reset", {dmar, intr, mem_en}, 0);
      for (int s = 0; s < 4; s++) begin
         rd(s[1:0], v);
         chk(v == 0, "R1", "register after reset", v, 0);
      end

      // R5 device to memory, cycle stealing, R2 write while busy
      wr(2'd0, 16'd8); wr(2'd1, 16'd4);
      x0 = n_xfer; d0 = n_drop;
      wr(2'd3, 16'h0001);
      wr(2'd0, 16'd40);
      wait_intr();
      chk(intr, "R10", "interrupt after steal run", intr, 1);
      for (int i = 0; i < 4; i++)
         chk(memarr[8+i] == 16'hA000 + i[15:0], "R5", "memory word", memarr[8+i], 16'hA000 + i[15:0]);
      chk(n_xfer - x0 == 4, "R4", "words moved", n_xfer - x0, 4);
      chk(n_drop - d0 == 4, "R6", "request drops", n_drop - d0, 4);
      rd(2'd0, v); chk(v == 16'd12, "R2", "address ignores busy write", v, 12);
      rd(2'd1, v); chk(v == 0, "R4", "count at end", v, 0);
      rd(2'd3, v); chk(v == 16'h0008, "R10", "status done", v, 16'h0008);
      repeat (4) @(negedge clk);
      #1 chk(intr, "R10", "interrupt held without inta", intr, 1);
      ack();
      #1 chk(!intr, "R10", "interrupt cleared by inta", intr, 0);

      // R5 memory to device, burst, R7
      wr(2'd0, 16'd8); wr(2'd1, 16'd5);
      d0 = n_drop;
      wr(2'd3, 16'h0007);
      rd(2'd3, v); chk(v == 16'h0007, "R12", "status busy burst dir", v, 16'h0007);
      wait_intr();
      chk(devq.size() == 5, "R5", "device words", devq.size(), 5);
      for (int i = 0; i < 5 && i < devq.size(); i++)
         chk(devq[i] == memarr[8+i], "R5", "device word", devq[i], memarr[8+i]);
      chk(n_drop - d0 == 1, "R7", "request held through burst", n_drop - d0, 1);
      rd(2'd2, v); chk(v == memarr[12], "R5", "holding register", v, memarr[12]);
      ack();

      // R8 grant while device not ready
      wr(2'd0, 16'd30); wr(2'd1, 16'd3);
      @(negedge clk); dev_ready = 1'b0;
      x0 = n_xfer;
      wr(2'd3, 16'h0001);
      for (int k = 0; k < 20 && !dmaa; k++) @(negedge clk);
      @(negedge clk); #1;
      chk(!dmar && n_xfer == x0, "R8", "request dropped on not-ready grant", dmar, 0);
      repeat (3) @(negedge clk);
      #1 chk(!dmar, "R8", "no request while not ready", dmar, 0);
      @(negedge clk); dev_ready = 1'b1;
      @(negedge clk); #1 chk(dmar, "R8", "request back after ready", dmar, 1);
      wait_intr();
      for (int i = 0; i < 3; i++)
         chk(memarr[30+i] == 16'hA004 + i[15:0], "R8", "retried word", memarr[30+i], 16'hA004 + i[15:0]);
      ack();

      // R9 zero count
      r0 = n_req;
      wr(2'd1, 16'd0);
      wr(2'd3, 16'h0001);
      #1 chk(intr, "R9", "interrupt on zero count", intr, 1);
      repeat (2) @(negedge clk);
      chk(n_req == r0, "R9", "no request on zero count", n_req - r0, 0);
      ack();

      // R11 device error
      wr(2'd0, 16'd50); wr(2'd1, 16'd6);
      x0 = n_xfer;
      wr(2'd3, 16'h0001);
      for (int k = 0; k < 200 && (n_xfer - x0) < 2; k++) @(negedge clk);
      dev_err = 1'b1;
      @(negedge clk); dev_err = 1'b0; #1;
      chk(intr && !dmar, "R11", "abort raises interrupt", {intr, dmar}, 2'b10);
      repeat (3) @(negedge clk);
      chk(n_xfer - x0 == 2, "R11", "no access after abort", n_xfer - x0, 2);
      rd(2'd1, v); chk(v == 16'd4, "R11", "count left", v, 4);
      rd(2'd3, v); chk(v == 16'h0018, "R11", "status error", v, 16'h0018);
      chk(memarr[52] == 16'h5034, "R11", "untouched word", memarr[52], 16'h5034);
      ack();

      // R7 burst with device stall, R12
      wr(2'd0, 16'd0); wr(2'd1, 16'd3);
      d0 = n_drop; x0 = n_xfer;
      wr(2'd3, 16'h0005);
      for (int k = 0; k < 200 && (n_xfer - x0) < 1; k++) @(negedge clk);
      dev_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1 chk(dmar && (n_xfer - x0) == 1, "R12", "no move while not ready", n_xfer - x0, 1);
      dev_ready = 1'b1;
      wait_intr();
      chk(n_drop - d0 == 1, "R7", "burst request held over stall", n_drop - d0, 1);
      ack();
      rd(2'd3, v); chk(v == 16'h000C, "R12", "status idle after ack", v, 16'h000C);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule